// File: doc/BRIEF.md
# Bus-Loaded Serial Output Buffer

This block sits behind a narrow CPU write port and turns a burst of byte writes into a serial bit stream. A single 8-bit write path is steered by a command/data select line. Data writes are queued in a 63-entry first-in first-out store. Command writes program the block. There are four commands: set the serial clock ratio, drive two general-purpose output pins, start the transmission, and empty the queue.

Once started, the block pops bytes from the queue and shifts each one out on a serial clock and data pair until the queue runs dry. The serial clock is derived from the system clock by a programmable power-of-two divider. When the last byte has left, an active-low interrupt is raised. The interrupt stays asserted until software writes the pin-control command. Typical use is driving a chain of shift-register latches: the two general-purpose pins act as the latch strobe and the output enable of that chain.

Top module: `pbuf_serial_out`

## Requirements
- R1: After reset `ser_clk`=0, `latch_o`=0, `oe_n`=1, `irq_n`=1, `overflow`=0, and the queue is empty.
- R2: A write is taken at the first `clk` edge that samples `wr_n` high after sampling it low, provided `sel_n` is low at that edge. `cmd_sel`=1 makes it a command and `cmd_sel`=0 makes it queue data. Writes with `sel_n` high have no effect.
- R3: The command type is `bus_data[7:6]`: 00 ratio, 01 pin control, 10 start, 11 empty queue.
- R4: The ratio command takes its code from `bus_data[1:0]`. Codes 0, 1, 2 and 3 give a `ser_clk` period of 2, 4, 8 and 16 `clk` cycles with a 50 % duty cycle.
- R5: A start command written before any ratio command since reset is ignored. No `ser_clk` edge and no interrupt follow it, and the queued data is kept.
- R6: The pin-control command drives `latch_o` from `bus_data[1]` and `oe_n` from `bus_data[0]`, and releases `irq_n` to 1.
- R7: Bytes are sent most significant bit first. `ser_dat` changes only while `ser_clk` is low, so it is stable across every rising edge. `ser_clk` rests low when no transmission is active.
- R8: The queue holds up to 63 bytes, and bytes are transmitted in the order they were written.
- R9: A data write to a full queue is dropped and sets the sticky `overflow` output. `overflow` is cleared only by the empty-queue command or by reset.
- R10: `irq_n` goes low once the final bit of the last queued byte has been clocked out. It also goes low when a start command finds the queue empty.
- R11: The empty-queue command discards every queued byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; the write is taken on its release |
| cmd_sel | input | 1 | 1 = command write, 0 = queue data write |
| bus_data | input | 8 | Write data bus |
| ser_clk | output | 1 | Serial shift clock, idle low |
| ser_dat | output | 1 | Serial data, MSB first |
| latch_o | output | 1 | General-purpose latch strobe pin |
| oe_n | output | 1 | General-purpose active-low output enable pin |
| irq_n | output | 1 | Active-low transfer-complete interrupt |
| overflow | output | 1 | Sticky queue overflow flag |

## Verification
A bus write takes effect at the clock edge that sees the strobe released, and every register it touches is updated at that edge. The bench drives the strobe on falling clock edges and reads `latch_o`, `oe_n`, `overflow` and `irq_n` at the next falling edge after the release. Serial bits have no fixed cycle of their own, so the bench samples `ser_dat` 1 ns after each rising `ser_clk` edge. It derives the clock period from the time between the first two rises. The end-of-transfer interrupt has a latency that depends on the ratio, so the bench polls for it with a bounded wait. A no-activity check counts `ser_clk` rises across a fixed window of 64 cycles.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned RATIO_W = 2;

    typedef enum logic [1:0] {
        CMD_RATIO = 2'b00,
        CMD_PINS  = 2'b01,
        CMD_SEND  = 2'b10,
        CMD_FLUSH = 2'b11
    } cmd_e;

    typedef struct packed {
        logic               wr_n;
        logic               latch;
        logic               oe_n;
        logic               irq_n;
        logic               ovf;
        logic [RATIO_W-1:0] ratio;
        logic               ratio_set;
    } ctl_t;
endpackage

// File: rtl/pbs_fifo.sv
module pbs_fifo #(
    parameter int unsigned DEPTH = 63,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (q.count == '0);
    assign full    = (q.count == CW'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign rdata   = mem[q.rd_ptr];

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (push_ok) d.wr_ptr = bump(q.wr_ptr);
            if (pop_ok)  d.rd_ptr = bump(q.rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   d.count = q.count + 1'b1;
                2'b01:   d.count = q.count - 1'b1;
                default: d.count = q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wr_ptr] <= wdata;
    end

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(q.count));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/pbs_clkdiv.sv
module pbs_clkdiv #(
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int unsigned MAX_HALF = 1 << ((1 << CODE_W) - 1);
    localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((1 << code) - 1);
    assign tick  = run && (cnt_q == limit);

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));
endmodule

// File: rtl/pbs_shifter.sv
module pbs_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         tick,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_data,
    output logic         pop,
    output logic         done,
    output logic         busy,
    output logic         sclk,
    output logic         sdat
);
    localparam int unsigned BW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          active;
        logic          sclk;
        logic [W-1:0]  shreg;
        logic [BW-1:0] bitcnt;
    } sh_st_t;

    sh_st_t q, d;

    always_comb begin
        d    = q;
        pop  = 1'b0;
        done = 1'b0;
        if (!q.active) begin
            if (start) begin
                if (fifo_empty) begin
                    done = 1'b1;
                end else begin
                    pop      = 1'b1;
                    d.active = 1'b1;
                    d.shreg  = fifo_data;
                    d.bitcnt = '0;
                    d.sclk   = 1'b0;
                end
            end
        end else if (tick) begin
            if (!q.sclk) begin
                d.sclk = 1'b1;
            end else begin
                d.sclk = 1'b0;
                if (q.bitcnt == BW'(W - 1)) begin
                    if (fifo_empty) begin
                        d.active = 1'b0;
                        done     = 1'b1;
                    end else begin
                        pop      = 1'b1;
                        d.shreg  = fifo_data;
                        d.bitcnt = '0;
                    end
                end else begin
                    d.shreg  = {q.shreg[W-2:0], 1'b0};
                    d.bitcnt = q.bitcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.active;
    assign sclk = q.sclk;
    assign sdat = q.shreg[W-1];

    // R7
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> !q.sclk);

    // R7
    sdat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sclk |-> $stable(q.shreg[W-1]));
endmodule

// File: rtl/pbuf_serial_out.sv
module pbuf_serial_out
    import pbs_pkg::*;
#(
    parameter int unsigned DEPTH = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              cmd_sel,
    input  logic [BYTE_W-1:0] bus_data,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              latch_o,
    output logic              oe_n,
    output logic              irq_n,
    output logic              overflow
);
    ctl_t q, d;

    logic              strobe, is_cmd, is_dat;
    logic              send, flush, pins_cmd, send_req;
    cmd_e              cmd;
    logic              fifo_empty, fifo_full, fifo_pop;
    logic [BYTE_W-1:0] fifo_rdata;
    logic              tick, sh_done, sh_busy;

    assign strobe = wr_n && !q.wr_n && !sel_n;
    assign is_cmd = strobe && cmd_sel;
    assign is_dat = strobe && !cmd_sel;
    assign cmd    = cmd_e'(bus_data[7:6]);

    always_comb begin
        d        = q;
        d.wr_n   = wr_n;
        send     = 1'b0;
        send_req = 1'b0;
        flush    = 1'b0;
        pins_cmd = 1'b0;
        if (is_cmd) begin
            case (cmd)
                CMD_RATIO: begin
                    d.ratio     = bus_data[RATIO_W-1:0];
                    d.ratio_set = 1'b1;
                end
                CMD_PINS: begin
                    pins_cmd = 1'b1;
                    d.latch  = bus_data[1];
                    d.oe_n   = bus_data[0];
                    d.irq_n  = 1'b1;
                end
                CMD_SEND: begin
                    send_req = 1'b1;
                    send     = q.ratio_set;
                end
                CMD_FLUSH: begin
                    flush = 1'b1;
                    d.ovf = 1'b0;
                end
                default: ;
            endcase
        end
        if (is_dat && fifo_full) d.ovf = 1'b1;
        if (sh_done)             d.irq_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.wr_n      <= 1'b1;
            q.oe_n      <= 1'b1;
            q.irq_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    pbs_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (is_dat),
        .wdata (bus_data),
        .pop   (fifo_pop),
        .flush (flush),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    pbs_clkdiv #(.CODE_W(RATIO_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_busy),
        .code  (q.ratio),
        .tick  (tick)
    );

    pbs_shifter #(.W(BYTE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (send),
        .tick       (tick),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_rdata),
        .pop        (fifo_pop),
        .done       (sh_done),
        .busy       (sh_busy),
        .sclk       (ser_clk),
        .sdat       (ser_dat)
    );

    assign latch_o  = q.latch;
    assign oe_n     = q.oe_n;
    assign irq_n    = q.irq_n;
    assign overflow = q.ovf;

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.irq_n) |-> $past(sh_done));

    // R9
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovf) |-> $past(is_dat && fifo_full));

    // R6
    pins_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({q.latch, q.oe_n}) |-> $past(pins_cmd));

    // R5
    send_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req && !q.ratio_set && !sh_busy) |=> !sh_busy);
endmodule

// File: tb/pbuf_serial_out_tb.sv
module pbuf_serial_out_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       cmd_sel = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       ser_clk, ser_dat, latch_o, oe_n, irq_n, overflow;

    int n_chk = 0;
    int n_err = 0;
    int rises = 0;
    time t_first, t_second;

    always #5 clk = ~clk;
    always @(posedge ser_clk) rises++;

    pbuf_serial_out u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
        .cmd_sel(cmd_sel), .bus_data(bus_data), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .latch_o(latch_o), .oe_n(oe_n),
        .irq_n(irq_n), .overflow(overflow)
    );

    // ratio code in [9:8], payload byte in [7:0]
    localparam logic [9:0] VEC [6] = '{
        {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'h81},
        {2'd3, 8'h7E}, {2'd0, 8'h00}, {2'd3, 8'hFF}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input bit cd, input logic [7:0] val, input bit cs);
        @(negedge clk);
        sel_n = !cs; cmd_sel = cd; bus_data = val; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        sel_n = 1'b1;
    endtask

    task automatic get_byte(output logic [7:0] b);
        b = '0;
        for (int k = 0; k < 8; k++) begin
            @(posedge ser_clk);
            if (k == 0) t_first = $time;
            if (k == 1) t_second = $time;
            #1;
            b = {b[6:0], ser_dat};
        end
    endtask

    task automatic wait_irq();
        int n = 0;
        while (irq_n && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] got;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset levels
        chk("R1 ser_clk", ser_clk, 0);
        chk("R1 latch_o", latch_o, 0);
        chk("R1 oe_n", oe_n, 1);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 overflow", overflow, 0);

        // R5 start before ratio programmed is ignored
        bus_write(1'b0, 8'h55, 1'b1);
        bus_write(1'b1, 8'h80, 1'b1);
        base = rises;
        repeat (64) @(negedge clk);
        chk("R5 no ser_clk", rises - base, 0);
        chk("R5 no irq", irq_n, 1);
        bus_write(1'b1, 8'h00, 1'b1);
        bus_write(1'b1, 8'h80, 1'b1);
        get_byte(got);
        chk("R5 queued byte kept", got, 8'h55);
        wait_irq();
        chk("R10 irq after byte", irq_n, 0);
        bus_write(1'b1, 8'h41, 1'b1);
        chk("R6 irq released", irq_n, 1);

        // table of ratio / byte vectors
        for (int i = 0; i < 6; i++) begin
            int code;
            code = int'(VEC[i][9:8]);
            bus_write(1'b1, {6'b0, VEC[i][9:8]}, 1'b1);
            bus_write(1'b0, VEC[i][7:0], 1'b1);
            bus_write(1'b1, 8'h80, 1'b1);
            get_byte(got);
            chk("R7 MSB-first byte", got, int'(VEC[i][7:0]));
            chk("R4 ser_clk period", int'((t_second - t_first) / 10), 2 << code);
            wait_irq();
            chk("R10 irq low", irq_n, 0);
            bus_write(1'b1, 8'h40 | 8'(i % 4), 1'b1);
            chk("R6 latch_o", latch_o, (i % 4) >> 1);
            chk("R6 oe_n", oe_n, i % 2);
            chk("R6 irq cleared", irq_n, 1);
            chk("R7 ser_clk idle", ser_clk, 0);
        end

        // R2 write with chip select inactive is ignored
        bus_write(1'b1, 8'h00, 1'b1);
        bus_write(1'b0, 8'h99, 1'b0);
        base = rises;
        bus_write(1'b1, 8'h80, 1'b1);
        repeat (8) @(negedge clk);
        chk("R2 deselected write dropped", rises - base, 0);
        chk("R10 irq on empty start", irq_n, 0);
        bus_write(1'b1, 8'h41, 1'b1);

        // R11 / R3 empty-queue command
        bus_write(1'b0, 8'h11, 1'b1);
        bus_write(1'b0, 8'h22, 1'b1);
        bus_write(1'b0, 8'h33, 1'b1);
        bus_write(1'b1, 8'hC0, 1'b1);
        base = rises;
        bus_write(1'b1, 8'h80, 1'b1);
        repeat (8) @(negedge clk);
        chk("R11 R3 flushed queue sends nothing", rises - base, 0);
        chk("R11 irq after flush start", irq_n, 0);
        bus_write(1'b1, 8'h41, 1'b1);

        // R8 / R9 fill to capacity, then overflow
        for (int i = 0; i < 63; i++) bus_write(1'b0, 8'(i * 3 + 1), 1'b1);
        chk("R9 no overflow at 63", overflow, 0);
        bus_write(1'b0, 8'hEE, 1'b1);
        chk("R9 overflow set", overflow, 1);
        base = rises;
        bus_write(1'b1, 8'h80, 1'b1);
        for (int i = 0; i < 63; i++) begin
            get_byte(got);
            chk("R8 order", got, (i * 3 + 1) & 8'hFF);
        end
        wait_irq();
        chk("R9 extra byte dropped", rises - base, 63 * 8);
        chk("R9 overflow sticky", overflow, 1);
        bus_write(1'b1, 8'hC0, 1'b1);
        chk("R9 overflow cleared", overflow, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule